// File: doc/BRIEF.md
# SPI NOR Flash Command Responder

This block is a synthesizable stand-in for a serial NOR flash device on an SPI bus. It watches an active-low select, a serial clock and a data-in line, decodes one-byte opcodes and answers on the data-out line. The contents live in an internal byte array whose size is a parameter and defaults to 2 KiB so that a simulation stays small. Bus addresses wider than the array alias onto it modulo its size.

The supported commands are identification read, write enable, switch to four-byte addressing, streaming read, page program, sector erase and full-array erase. Several commands may be chained inside one select frame. Erases take effect when the select is released. Programming can only turn ones into zeros. The bus pins are brought into the system clock domain through a synchronizer and then edge-detected, so the serial clock must run well below the system clock.

Top module: `spi_nor_responder`

## Requirements
- R1: Opcode 0x9F returns the 24-bit ID parameter (default 0x20BA19) on MISO as three bytes, most significant byte first; any further bytes in that frame read 0x00.
- R2: Opcode 0x03 followed by an address, sent most significant byte first, streams bytes from array index (address mod MEM_BYTES), incrementing by one per byte. The stream crosses page boundaries and wraps at the array end for as long as the select stays low.
- R3: After opcode 0xB7, every later address in any frame takes four bytes instead of three, until reset. An address above 16 MiB therefore reaches index (address mod MEM_BYTES).
- R4: After 0x06 or 0xB7, the next byte in the same frame is decoded as a new opcode.
- R5: Opcode 0x02 plus address writes each following byte to consecutive locations. Only the low 8 address bits advance, so writes wrap within the 256-byte page. No write enable is needed.
- R6: A programmed byte becomes old AND data, so a bit can be cleared but never set.
- R7: Opcode 0xD8 plus address, with the write-enable latch set, turns every byte of the sector holding that address (aligned down to SECTOR_BYTES, default 512) into 0xFF when the select rises. Bytes outside that sector keep their values.
- R8: Opcode 0xC7, with the write-enable latch set, turns every byte of the array into 0xFF when the select rises.
- R9: An erase is ignored when the write-enable latch is clear. The latch is cleared when the select rises at the end of any frame that contained a 0x02, 0xD8 or 0xC7 opcode.
- R10: A rising select abandons any partial byte or unfinished command, and the next frame starts with an opcode. An unknown opcode causes the rest of its frame to be ignored.
- R11: After reset the array holds INIT_BYTE (default 0x00), addressing is three-byte, the latch is clear, and MISO is 0 whenever the device is deselected.
- R12: Mode 0 timing applies: MOSI is sampled at rising SCK and MISO changes after falling SCK. The first bit of each returned byte is valid before the first rising edge of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low device select |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial data out of the device |

## Verification
The hardest state to reach is a write-enable latch that is set while an erase is still skipped, or cleared while an erase is still honoured. Reaching it takes frame sequences: the enable alone in its own frame, a program frame that silently consumes the latch, an unknown opcode that swallows a following enable, and an erase cut short before its last address byte. The bench drives these directed frames first and then runs seeded random program and erase frames, some with and some without a leading enable. A byte-level model follows the latch and the contents, and every byte read back is compared with that model.

// File: rtl/nfr_pkg.sv
package nfr_pkg;
   typedef enum logic [2:0] {
      ST_OPC, ST_ADDR, ST_READ, ST_PROG, ST_ID, ST_ERPEND, ST_SKIP
   } nfr_state_e;

   typedef enum logic [1:0] { AC_READ, AC_PROG, AC_ERASE } nfr_acmd_e;

   localparam logic [7:0] OP_IDENT = 8'h9F;
   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_ADDR4 = 8'hB7;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_PROG  = 8'h02;
   localparam logic [7:0] OP_SECER = 8'hD8;
   localparam logic [7:0] OP_BULK  = 8'hC7;
endpackage

// File: rtl/nfr_sync.sv
module nfr_sync #(
   parameter int         WIDTH   = 3,
   parameter int         STAGES  = 2,
   parameter logic [2:0] RST_VAL = 3'b001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL[WIDTH-1:0];
            end else begin
               stage_q[0] <= din;
               for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            end
         end
         assign dout = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/nfr_store.sv
module nfr_store #(
   parameter int         MEM_BYTES    = 2048,
   parameter int         SECTOR_BYTES = 512,
   parameter logic [7:0] INIT_BYTE    = 8'h00,
   localparam int        AW           = $clog2(MEM_BYTES),
   localparam int        SW           = $clog2(SECTOR_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_idx,
   output logic [7:0]    rd_data,
   input  logic          prog_en,
   input  logic [AW-1:0] prog_idx,
   input  logic [7:0]    prog_data,
   input  logic          sec_erase_en,
   input  logic          bulk_erase_en,
   input  logic [AW-1:0] erase_idx
);
   logic [7:0] mem_q [MEM_BYTES];
   logic [AW-1:0] erase_sec;

   assign erase_sec = erase_idx >> SW;
   assign rd_data   = mem_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= INIT_BYTE;
      end else begin
         for (int i = 0; i < MEM_BYTES; i++) begin
            if (bulk_erase_en || (sec_erase_en && ((AW'(i) >> SW) == erase_sec)))
               mem_q[i] <= 8'hFF;
            else if (prog_en && (prog_idx == AW'(i)))
               mem_q[i] <= mem_q[i] & prog_data;
         end
      end
   end

   // checker state for the program rule
   logic          chk_vld_q;
   logic [AW-1:0] chk_idx_q;
   logic [7:0]    chk_old_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_vld_q <= 1'b0;
         chk_idx_q <= '0;
         chk_old_q <= 8'h00;
      end else begin
         chk_vld_q <= prog_en && !sec_erase_en && !bulk_erase_en;
         chk_idx_q <= prog_idx;
         chk_old_q <= mem_q[prog_idx];
      end
   end

   // R6: programming never sets a bit
   p_prog_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chk_vld_q |-> ((mem_q[chk_idx_q] & ~chk_old_q) == 8'h00));

   // R8: full erase reaches both ends of the array
   p_bulk_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bulk_erase_en |=> (mem_q[0] == 8'hFF && mem_q[MEM_BYTES-1] == 8'hFF));
endmodule

// File: rtl/nfr_ctrl.sv
module nfr_ctrl
   import nfr_pkg::*;
#(
   parameter int          AW         = 11,
   parameter int          PAGE_BYTES = 256,
   parameter logic [23:0] ID_VALUE   = 24'h20BA19,
   localparam int         PW         = $clog2(PAGE_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_act,
   input  logic          sck_s,
   input  logic          mosi_s,
   output logic          miso,
   output logic [AW-1:0] rd_idx,
   input  logic [7:0]    rd_data,
   output logic          prog_en,
   output logic [AW-1:0] prog_idx,
   output logic [7:0]    prog_data,
   output logic          sec_erase_en,
   output logic          bulk_erase_en,
   output logic [AW-1:0] erase_idx
);
   nfr_state_e state_q;
   nfr_acmd_e  acmd_q;
   logic [2:0]  bit_q;
   logic [6:0]  shin_q;
   logic [31:0] addr_q;
   logic [1:0]  abytes_q, id_idx_q;
   logic [7:0]  tx_q, rx_byte, id_byte;
   logic        four_q, wel_q, frame_wr_q, bulk_q, sck_q, cs_q;
   logic        sck_rise, sck_fall, cs_rise, byte_done, addr_last;

   assign sck_rise  = cs_act && sck_s && !sck_q;
   assign sck_fall  = cs_act && !sck_s && sck_q;
   assign cs_rise   = cs_q && !cs_act;
   assign rx_byte   = {shin_q, mosi_s};
   assign byte_done = sck_rise && (bit_q == 3'd7);
   assign addr_last = (abytes_q == (four_q ? 2'd3 : 2'd2));

   always_comb begin
      case (id_idx_q)
         2'd0:    id_byte = ID_VALUE[23:16];
         2'd1:    id_byte = ID_VALUE[15:8];
         2'd2:    id_byte = ID_VALUE[7:0];
         default: id_byte = 8'h00;
      endcase
   end

   assign rd_idx        = addr_q[AW-1:0];
   assign prog_idx      = addr_q[AW-1:0];
   assign prog_data     = rx_byte;
   assign prog_en       = byte_done && (state_q == ST_PROG);
   assign erase_idx     = addr_q[AW-1:0];
   assign sec_erase_en  = cs_rise && (state_q == ST_ERPEND) && wel_q && !bulk_q;
   assign bulk_erase_en = cs_rise && (state_q == ST_ERPEND) && wel_q && bulk_q;
   assign miso          = tx_q[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OPC;   acmd_q <= AC_READ;  bit_q <= '0;
         shin_q <= '0;        addr_q <= '0;       abytes_q <= '0;
         id_idx_q <= '0;      tx_q <= '0;         four_q <= 1'b0;
         wel_q <= 1'b0;       frame_wr_q <= 1'b0; bulk_q <= 1'b0;
         sck_q <= 1'b0;       cs_q <= 1'b0;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_act;
         if (!cs_act) begin
            state_q <= ST_OPC;  bit_q <= '0;  addr_q <= '0;
            abytes_q <= '0;     tx_q <= '0;   frame_wr_q <= 1'b0;
            if (cs_rise && frame_wr_q) wel_q <= 1'b0;
         end else begin
            if (sck_rise) begin
               shin_q <= rx_byte[6:0];
               bit_q  <= bit_q + 3'd1;
            end
            if (byte_done) begin
               case (state_q)
                  ST_OPC: begin
                     abytes_q <= '0;
                     case (rx_byte)
                        OP_IDENT: begin state_q <= ST_ID; id_idx_q <= '0; end
                        OP_WREN:  wel_q  <= 1'b1;
                        OP_ADDR4: four_q <= 1'b1;
                        OP_READ:  begin state_q <= ST_ADDR; acmd_q <= AC_READ; end
                        OP_PROG:  begin state_q <= ST_ADDR; acmd_q <= AC_PROG;
                                        frame_wr_q <= 1'b1; end
                        OP_SECER: begin state_q <= ST_ADDR; acmd_q <= AC_ERASE;
                                        frame_wr_q <= 1'b1; bulk_q <= 1'b0; end
                        OP_BULK:  begin state_q <= ST_ERPEND; frame_wr_q <= 1'b1;
                                        bulk_q <= 1'b1; end
                        default:  state_q <= ST_SKIP;
                     endcase
                  end
                  ST_ADDR: begin
                     addr_q   <= {addr_q[23:0], rx_byte};
                     abytes_q <= abytes_q + 2'd1;
                     if (addr_last) begin
                        case (acmd_q)
                           AC_READ: state_q <= ST_READ;
                           AC_PROG: state_q <= ST_PROG;
                           default: state_q <= ST_ERPEND;
                        endcase
                     end
                  end
                  ST_PROG: addr_q[PW-1:0] <= addr_q[PW-1:0] + PW'(1);
                  default: ;
               endcase
            end
            if (sck_fall) begin
               if (bit_q == 3'd0 && state_q == ST_READ) begin
                  tx_q   <= rd_data;
                  addr_q <= addr_q + 32'd1;
               end else if (bit_q == 3'd0 && state_q == ST_ID) begin
                  tx_q <= id_byte;
                  if (id_idx_q != 2'd3) id_idx_q <= id_idx_q + 2'd1;
               end else begin
                  tx_q <= {tx_q[6:0], 1'b0};
               end
            end
         end
      end
   end

   // R3: four-byte addressing never drops back without reset
   p_four_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      four_q |=> four_q);

   // R9: a frame that held a write command leaves the latch clear
   p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && frame_wr_q) |=> !wel_q);

   // R5: programming stays inside its page
   p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      prog_en |=> (addr_q[31:PW] == $past(addr_q[31:PW])));

   // R11: deselected device keeps MISO low
   p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_act && !cs_q) |-> !miso);
endmodule

// File: rtl/spi_nor_responder.sv
module spi_nor_responder #(
   parameter int          MEM_BYTES    = 2048,
   parameter int          SECTOR_BYTES = 512,
   parameter int          PAGE_BYTES   = 256,
   parameter logic [23:0] ID_VALUE     = 24'h20BA19,
   parameter logic [7:0]  INIT_BYTE    = 8'h00,
   parameter int          SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sck,
   input  logic spi_mosi,
   output logic spi_miso
);
   localparam int AW = $clog2(MEM_BYTES);

   generate
      if ((MEM_BYTES & (MEM_BYTES - 1)) != 0 || MEM_BYTES < 2 || MEM_BYTES > 4096) begin : g_bad_mem
         $error("MEM_BYTES must be a power of two between 2 and 4096");
      end
      if ((SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0 || SECTOR_BYTES > MEM_BYTES) begin : g_bad_sec
         $error("SECTOR_BYTES must be a power of two no larger than MEM_BYTES");
      end
      if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 2 || PAGE_BYTES > SECTOR_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two between 2 and SECTOR_BYTES");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [2:0] pins_s;
   logic [AW-1:0] rd_idx, prog_idx, erase_idx;
   logic [7:0] rd_data, prog_data;
   logic prog_en, sec_erase_en, bulk_erase_en;

   nfr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .din({spi_mosi, spi_sck, spi_cs_n}), .dout(pins_s));

   nfr_ctrl #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .ID_VALUE(ID_VALUE)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cs_act(!pins_s[0]), .sck_s(pins_s[1]), .mosi_s(pins_s[2]),
      .miso(spi_miso),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .prog_en(prog_en), .prog_idx(prog_idx), .prog_data(prog_data),
      .sec_erase_en(sec_erase_en), .bulk_erase_en(bulk_erase_en),
      .erase_idx(erase_idx));

   nfr_store #(.MEM_BYTES(MEM_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
               .INIT_BYTE(INIT_BYTE)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .prog_en(prog_en), .prog_idx(prog_idx), .prog_data(prog_data),
      .sec_erase_en(sec_erase_en), .bulk_erase_en(bulk_erase_en),
      .erase_idx(erase_idx));
endmodule

// File: tb/tb_spi_nor_responder.sv
`timescale 1ns/1ps
module tb_spi_nor_responder;
   localparam int MEMB = 2048;
   localparam int SECB = 512;
   localparam int H    = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
   logic miso;
   always #2 clk = ~clk;

   spi_nor_responder dut (.clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n),
      .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso));

   logic [7:0] model [MEMB];
   bit four_m, wel_m, done;
   int checks, errors;
   logic [7:0] pd [8];
   logic [7:0] dummy;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
      rx = 8'h00;
      for (int b = 7; b > 7 - n; b--) begin
         mosi = tx[b];
         wclk(H);
         rx[b] = miso;
         sck = 1'b1;
         wclk(H);
         sck = 1'b0;
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      xbits(tx, 8, rx);
   endtask

   task automatic sel();
      cs_n = 1'b0; wclk(H);
   endtask

   task automatic desel();
      wclk(H); cs_n = 1'b1; wclk(H + 6);
   endtask

   task automatic send_addr(input logic [31:0] a);
      if (four_m) xfer(a[31:24], dummy);
      xfer(a[23:16], dummy); xfer(a[15:8], dummy); xfer(a[7:0], dummy);
   endtask

   function automatic int mi(input logic [31:0] a);
      return int'(a[10:0]);
   endfunction

   task automatic do_read(input logic [31:0] a, input int n, input string req);
      logic [7:0] rx;
      sel(); xfer(8'h03, dummy); send_addr(a);
      for (int i = 0; i < n; i++) begin
         xfer(8'h00, rx);
         chk(req, rx, model[mi(a + i)]);
      end
      desel();
   endtask

   task automatic do_prog(input logic [31:0] a, input int n, input bit wren);
      sel();
      if (wren) begin xfer(8'h06, dummy); wel_m = 1; end
      xfer(8'h02, dummy); send_addr(a);
      for (int i = 0; i < n; i++) begin
         logic [31:0] pa;
         xfer(pd[i], dummy);
         pa = {a[31:8], a[7:0] + 8'(i)};
         model[mi(pa)] = model[mi(pa)] & pd[i];
      end
      desel(); wel_m = 0;
   endtask

   task automatic do_erase(input logic [31:0] a, input bit wren, input bit bulk);
      sel();
      if (wren) begin xfer(8'h06, dummy); wel_m = 1; end
      if (bulk) xfer(8'hC7, dummy);
      else begin xfer(8'hD8, dummy); send_addr(a); end
      desel();
      if (wel_m) begin
         for (int i = 0; i < MEMB; i++)
            if (bulk || (i / SECB) == (mi(a) / SECB)) model[i] = 8'hFF;
      end
      wel_m = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rx;
      int unsigned seed;
      for (int i = 0; i < MEMB; i++) model[i] = 8'h00;
      seed = 32'h5eed_0042;
      void'($urandom(seed));
      wclk(10); rst_n = 1'b1; wclk(4);

      // R11 reset state, three-byte read of initial contents (R2)
      chk("R11 miso idle", {31'd0, miso}, 32'd0);
      do_read(32'h0000_0123, 3, "R11/R2 reset read");

      // R1 identification, R12 first bit ready before first rise
      sel(); xfer(8'h9F, dummy);
      xfer(8'h00, rx); chk("R1 id byte0 R12", rx, 8'h20);
      xfer(8'h00, rx); chk("R1 id byte1", rx, 8'hBA);
      xfer(8'h00, rx); chk("R1 id byte2", rx, 8'h19);
      xfer(8'h00, rx); chk("R1 id trailing", rx, 8'h00);
      desel();
      chk("R11 miso after frame", {31'd0, miso}, 32'd0);

      // R4 chained enable, 4-byte switch and sector erase (R7)
      sel(); xfer(8'h06, dummy); xfer(8'hB7, dummy); xfer(8'hD8, dummy);
      four_m = 1; wel_m = 1;
      send_addr(32'h0000_0345);
      desel();
      for (int i = 0; i < MEMB; i++) if (i / SECB == 1) model[i] = 8'hFF;
      wel_m = 0;
      do_read(32'h0000_01FE, 4, "R7/R4 sector low edge");
      do_read(32'h0000_03FE, 4, "R7 sector high edge");
      do_read(32'h0100_0200, 2, "R3 above 16MiB");

      // R5 program wraps in page, no enable needed
      pd[0] = 8'hA1; pd[1] = 8'hB2; pd[2] = 8'hC3; pd[3] = 8'hD4;
      do_prog(32'h0100_02FE, 4, 0);
      do_read(32'h0000_02FC, 8, "R2/R5 cross page");
      do_read(32'h0000_0200, 2, "R5 page wrap");
      sel(); xfer(8'h03, dummy); send_addr(32'h0000_0200);
      xfer(8'h00, rx); desel();
      chk("R5 wrapped byte", rx, 8'hC3);

      // R6 AND semantics
      pd[0] = 8'h0F;
      do_prog(32'h0000_02FE, 1, 0);
      do_read(32'h0000_02FE, 1, "R6 and");
      sel(); xfer(8'h03, dummy); send_addr(32'h0000_02FE);
      xfer(8'h00, rx); desel();
      chk("R6 value", rx, 8'h01);

      // R9 erase without enable, and enable consumed by program frame
      do_erase(32'h0000_0200, 0, 0);
      do_read(32'h0000_0200, 2, "R9 no latch");
      sel(); xfer(8'h06, dummy); desel(); wel_m = 1;
      pd[0] = 8'hFF; do_prog(32'h0000_0500, 1, 0);
      do_erase(32'h0000_0200, 0, 0);
      do_read(32'h0000_0200, 2, "R9 latch consumed");

      // R10 unknown opcode swallows a following enable
      sel(); xfer(8'h5A, dummy); xfer(8'h06, dummy); desel();
      do_erase(32'h0000_0200, 0, 0);
      do_read(32'h0000_0200, 2, "R10 unknown opcode");

      // R10 partial data byte in a program frame
      sel(); xfer(8'h02, dummy); send_addr(32'h0000_0210);
      xbits(8'h00, 5, dummy); desel(); wel_m = 0;
      do_read(32'h0000_0210, 1, "R10 partial byte");

      // R10 erase cut before its last address byte
      sel(); xfer(8'h06, dummy); xfer(8'hD8, dummy);
      xfer(8'h00, dummy); xfer(8'h00, dummy); desel(); wel_m = 0;
      do_read(32'h0000_0200, 2, "R10 aborted erase");

      // R10 partial opcode, next frame decodes cleanly
      sel(); xbits(8'h03, 4, dummy); desel();
      sel(); xfer(8'h9F, dummy); xfer(8'h00, rx); desel();
      chk("R10 after partial opcode", rx, 8'h20);

      // random program and erase frames
      for (int it = 0; it < 24; it++) begin
         int unsigned r;
         logic [31:0] a;
         int n;
         r = $urandom % 6;
         a = $urandom;
         if (r == 0) begin
            do_erase(a, 1, 0);
            do_read(a - 32'd2, 4, "R7 random");
         end else begin
            n = 1 + int'($urandom % 6);
            for (int k = 0; k < n; k++) pd[k] = 8'($urandom);
            do_prog(a, n, r == 1);
            do_read({a[31:8], 8'h00} + {24'd0, a[7:0]} - 32'd1, n + 2, "R5/R6 random");
         end
      end

      // R9 bulk erase ignored without enable
      pd[0] = 8'h3C; do_prog(32'h0000_0040, 1, 0);
      do_erase(32'h0, 0, 1);
      do_read(32'h0000_0040, 1, "R9 bulk no latch");

      // R8 bulk erase with enable, read wraps at array end (R2)
      do_erase(32'h0, 1, 1);
      do_read(32'h0000_07FE, 4, "R8/R2 array wrap");
      do_read(32'h0000_0040, 2, "R8 bulk");
      do_read(32'h0000_0500, 2, "R8 bulk mid");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule